// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Staged Updates

This block generates four independent pulse-width modulated outputs. Each channel has a prescaler that slows the clock down, and a period counter that steps once per prescaled tick. The output is high at the start of each period and goes low once the counter reaches the programmed high-time count. Software programs every channel through a small synchronous register bus that uses word addresses.

The modulus (period length in ticks) and the prescale value are first written into staging registers. They do not affect the output on their own. A write to the duty register bundles the staged prescale and modulus with the new duty value into a committed set. The running channel takes up the committed set only when its current period ends, so no single period mixes old and new settings. Clearing the enable bit is different: the output drops at once, mid-period, and both counters restart from zero.

A channel that is disabled always tracks its committed set. Enabling it therefore starts a fresh period with the latest committed values straight away.

Top module: `pwm_multi`

## Requirements
- R1: Channel c occupies word addresses 8*c to 8*c+7 (byte offset c*32). Within a bank, word 0 is prescale, word 1 is modulus, word 2 is duty and word 6 is enable (byte offsets 0x00, 0x04, 0x08, 0x18).
- R2: Prescale and modulus are 8-bit fields and duty is a 16-bit field. Enable is data bit 0. Reading any of these words returns the last value written to it, truncated to its field and zero-extended.
- R3: After reset every channel is disabled, every output is low and every register reads zero.
- R4: While a channel is enabled with prescale P, modulus M > 0 and duty D < M, its output repeats a period of (P+1)*M cycles. The period starts with (P+1)*D cycles high and is low for the rest.
- R5: Writing prescale or modulus without a later duty write leaves the waveform unchanged.
- R6: A duty write commits the staged prescale, the staged modulus and the new duty value together. A running channel applies them at the end of the period in progress, so that period completes with the old values.
- R7: Writing 0 to enable drives the output low in the first cycle after the write, without waiting for the period to end.
- R8: Enabling a disabled channel applies its committed values at once and starts a new period, high first when D > 0.
- R9: D = 0 holds the output low, D >= M holds it high, and M = 0 holds it low.
- R10: Words 3, 4, 5 and 7 of every bank read as zero, and writes to them change no register and no output.
- R11: The four channels run independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock driving counters and registers |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Word address: channel in bits 4:3, word in bits 2:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The embedded assertions check several properties on every cycle. Both counters stay inside their committed ranges. The active settings never change in the middle of an enabled period. A write that does not target the duty register never alters the committed set. An enable-clear write is always followed by a low output. Unmapped reads always return zero. Only the bench scenarios can show the waveform itself: the measured high and period lengths, the old high time surviving a duty write made mid-pulse, the instant restart after enable, the constant-level corner cases, and channel independence.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int WORD_W  = 3;   // word index inside one channel bank
    localparam int PRE_W   = 8;
    localparam int MOD_W   = 8;
    localparam int DUTY_W  = 16;
    localparam int DATA_W  = 16;  // bus width = widest field

    typedef enum logic [WORD_W-1:0] {
        RW_PRESCALE = 3'd0,
        RW_MODULUS  = 3'd1,
        RW_DUTY     = 3'd2,
        RW_ENABLE   = 3'd6
    } reg_word_e;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MOD_W-1:0]  mod;
        logic [DUTY_W-1:0] duty;
    } pwm_cfg_t;

    function automatic logic word_mapped(input logic [WORD_W-1:0] w);
        case (reg_word_e'(w))
            RW_PRESCALE, RW_MODULUS, RW_DUTY, RW_ENABLE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] read_word(
        input logic [WORD_W-1:0] w,
        input logic [PRE_W-1:0]  pre,
        input logic [MOD_W-1:0]  mod,
        input logic [DUTY_W-1:0] duty,
        input logic              en
    );
        case (reg_word_e'(w))
            RW_PRESCALE: return DATA_W'(pre);
            RW_MODULUS:  return DATA_W'(mod);
            RW_DUTY:     return DATA_W'(duty);
            RW_ENABLE:   return DATA_W'(en);
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [PRE_W-1:0]  stage_pre_o,
    output logic [MOD_W-1:0]  stage_mod_o,
    output pwm_cfg_t          cmt_o,
    output logic              commit_o,
    output logic              en_o
);

    logic [PRE_W-1:0] stage_pre;
    logic [MOD_W-1:0] stage_mod;
    pwm_cfg_t         cmt;
    logic             commit_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_pre <= '0;
            stage_mod <= '0;
            cmt       <= '0;
            commit_q  <= 1'b0;
            en_q      <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (wr_i) begin
                case (reg_word_e'(word_i))
                    RW_PRESCALE: stage_pre <= wdata_i[PRE_W-1:0];
                    RW_MODULUS:  stage_mod <= wdata_i[MOD_W-1:0];
                    RW_DUTY: begin
                        cmt.pre  <= stage_pre;
                        cmt.mod  <= stage_mod;
                        cmt.duty <= wdata_i[DUTY_W-1:0];
                        commit_q <= 1'b1;
                    end
                    RW_ENABLE:   en_q <= wdata_i[0];
                    default: ;
                endcase
            end
        end
    end

    assign stage_pre_o = stage_pre;
    assign stage_mod_o = stage_mod;
    assign cmt_o       = cmt;
    assign commit_o    = commit_q;
    assign en_o        = en_q;

    AST_STAGE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (reg_word_e'(word_i) != RW_DUTY)) |=> ($stable(cmt) && !commit_q))
        else $error("staging write altered committed set"); // R5

endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
    import pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_i,
    input  pwm_cfg_t cfg_i,
    input  logic     commit_i,
    output logic     pwm_o
);

    pwm_cfg_t         act;
    logic             pend;
    logic [PRE_W-1:0] pre_cnt;
    logic [MOD_W-1:0] per_cnt;
    logic             tick;
    logic             last_step;
    logic             wrap;

    assign tick      = (pre_cnt == act.pre);
    assign last_step = (act.mod == '0) || (per_cnt == act.mod - 1'b1);
    assign wrap      = tick && last_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= '0;
            pend    <= 1'b0;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else if (!en_i) begin
            act     <= cfg_i;
            pend    <= 1'b0;
            pre_cnt <= '0;
            per_cnt <= '0;
        end else begin
            if (tick) begin
                pre_cnt <= '0;
                per_cnt <= last_step ? '0 : per_cnt + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
            if (wrap) begin
                pend <= 1'b0;
                if (pend || commit_i)
                    act <= cfg_i;
            end else if (commit_i) begin
                pend <= 1'b1;
            end
        end
    end

    assign pwm_o = en_i && (act.mod != '0) && (DUTY_W'(per_cnt) < act.duty);

    AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (en_i && act.mod != '0) |-> (per_cnt < act.mod))
        else $error("period counter beyond modulus"); // R4

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
        en_i |-> (pre_cnt <= act.pre))
        else $error("prescale counter beyond limit"); // R4

    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
        (en_i && $past(en_i) && !$past(wrap)) |-> $stable(act))
        else $error("settings changed inside a period"); // R6

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [CH_W-1:0]   sel_ch;
    logic [WORD_W-1:0] sel_word;
    logic              ch_ok;
    logic [DATA_W-1:0] rd_words [NUM_CH];

    assign sel_ch   = bus_addr[ADDR_W-1:WORD_W];
    assign sel_word = bus_addr[WORD_W-1:0];
    assign ch_ok    = (32'(sel_ch) < 32'(NUM_CH));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [PRE_W-1:0] st_pre;
        logic [MOD_W-1:0] st_mod;
        pwm_cfg_t         cmt;
        logic             commit;
        logic             en;
        logic             hit;

        assign hit = bus_wr && (sel_ch == CH_W'(g));

        pwm_chan_regs u_regs (
            .clk         (clk),
            .rst         (rst),
            .wr_i        (hit),
            .word_i      (sel_word),
            .wdata_i     (bus_wdata),
            .stage_pre_o (st_pre),
            .stage_mod_o (st_mod),
            .cmt_o       (cmt),
            .commit_o    (commit),
            .en_o        (en)
        );

        pwm_chan_core u_core (
            .clk      (clk),
            .rst      (rst),
            .en_i     (en),
            .cfg_i    (cmt),
            .commit_i (commit),
            .pwm_o    (pwm_out[g])
        );

        assign rd_words[g] = read_word(sel_word, st_pre, st_mod, cmt.duty, en);

        AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (rst)
            (hit && (reg_word_e'(sel_word) == RW_ENABLE) && !bus_wdata[0]) |=> !pwm_out[g])
            else $error("output not low after enable clear"); // R7
    end

    assign bus_rdata = ch_ok ? rd_words[sel_ch] : '0;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !word_mapped(sel_word) |-> (bus_rdata == '0))
        else $error("unmapped word read nonzero"); // R10

endmodule

// File: tb/pwm_multi_tb.sv
module pwm_multi_tb;
    import pwm_pkg::*;

    localparam int NUM_CH = 4;
    localparam int LIM    = 4000;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        int    ch;
        int    hi;
        int    per;
        string req;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    pwm_multi #(.NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wa(input int ch, input int w);
        return ch * 8 + w;
    endfunction

    task automatic wr(input int a, input int d);
        bus_wr    = 1'b1;
        bus_addr  = 5'(a);
        bus_wdata = 16'(d);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = 5'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic setup(input int ch, input int p, input int m, input int d);
        wr(wa(ch, 0), p);
        wr(wa(ch, 1), m);
        wr(wa(ch, 2), d);
    endtask

    // driver side: push an expected waveform and wait until the monitor consumed it
    task automatic expect_wave(input int ch, input int hi, input int per, input string req);
        exp_t e;
        e.ch = ch; e.hi = hi; e.per = per; e.req = req;
        q.push_back(e);
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic wait_rise(input int ch);
        int t = 0;
        while (pwm_out[ch] == 1'b1 && t < LIM) begin @(negedge clk); t++; end
        while (pwm_out[ch] == 1'b0 && t < LIM) begin @(negedge clk); t++; end
    endtask

    task automatic count_high(input int ch, output int hi);
        hi = 0;
        while (pwm_out[ch] == 1'b1 && hi < LIM) begin hi++; @(negedge clk); end
    endtask

    task automatic highs_in(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch]) hi++;
            @(negedge clk);
        end
    endtask

    // monitor: measures one full period per queued item and compares
    initial begin
        forever begin
            int hi;
            int lo;
            int t;
            while (q.size() == 0) @(negedge clk);
            wait_rise(q[0].ch);
            hi = 0; lo = 0; t = 0;
            while (pwm_out[q[0].ch] == 1'b1 && t < LIM) begin hi++; t++; @(negedge clk); end
            while (pwm_out[q[0].ch] == 1'b0 && t < LIM) begin lo++; t++; @(negedge clk); end
            check({q[0].req, " high cycles"}, hi, q[0].hi);
            check({q[0].req, " period cycles"}, hi + lo, q[0].per);
            void'(q.pop_front());
        end
    end

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int v;
        int hi;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3 reset state
        check("R3 outputs", int'(pwm_out), 0);
        rd(wa(0, 6), v); check("R3 enable ch0", v, 0);
        rd(wa(1, 2), v); check("R3 duty ch1", v, 0);
        rd(wa(3, 0), v); check("R3 prescale ch3", v, 0);

        // R2 readback and field widths on ch3
        wr(wa(3, 0), 'h1FF); rd(wa(3, 0), v); check("R2 prescale truncated", v, 'hFF);
        wr(wa(3, 1), 'h3C7); rd(wa(3, 1), v); check("R2 modulus truncated", v, 'hC7);
        wr(wa(3, 2), 'hA345); rd(wa(3, 2), v); check("R2 duty 16 bits", v, 'hA345);
        wr(wa(3, 6), 3); rd(wa(3, 6), v); check("R2 enable bit0", v, 1);
        wr(wa(3, 6), 0); rd(wa(3, 6), v); check("R2 enable cleared", v, 0);

        // R4 basic waveform on ch0, R11 second channel running alongside
        setup(0, 1, 10, 3);
        wr(wa(0, 6), 1);
        setup(1, 0, 8, 5);
        wr(wa(1, 6), 1);
        expect_wave(0, 6, 20, "R4 ch0 P1 M10 D3");
        expect_wave(1, 5, 8, "R11 ch1 P0 M8 D5");

        // R1 bank stride: channel 2 at words 16..23
        setup(2, 0, 4, 1);
        wr(wa(2, 6), 1);
        rd(16 + 2, v); check("R1 ch2 duty word", v, 1);
        rd(16 + 1, v); check("R1 ch2 modulus word", v, 4);
        expect_wave(2, 1, 4, "R1 ch2 P0 M4 D1");
        expect_wave(0, 6, 20, "R11 ch0 unaffected by ch2");

        // R5 staging without duty write
        wr(wa(0, 1), 4);
        wr(wa(0, 0), 0);
        rd(wa(0, 1), v); check("R5 staged modulus reads back", v, 4);
        expect_wave(0, 6, 20, "R5 waveform unchanged");

        // R6 duty write mid-pulse: running period keeps old high time
        wait_rise(0);
        wr(wa(0, 2), 2);
        count_high(0, hi);
        check("R6 old high time kept", hi + 1, 6);
        expect_wave(0, 2, 4, "R6 new settings next period");

        // R10 unmapped words
        wr(wa(0, 3), 'hFF);
        wr(wa(0, 4), 'h55);
        wr(wa(0, 7), 'h1);
        rd(wa(0, 3), v); check("R10 word3 reads zero", v, 0);
        rd(wa(0, 4), v); check("R10 word4 reads zero", v, 0);
        rd(wa(0, 5), v); check("R10 word5 reads zero", v, 0);
        rd(wa(0, 7), v); check("R10 word7 reads zero", v, 0);
        rd(wa(0, 2), v); check("R10 duty untouched", v, 2);
        expect_wave(0, 2, 4, "R10 waveform untouched");

        // R7 immediate stop mid-pulse
        wait_rise(1);
        wr(wa(1, 6), 0);
        check("R7 low right after clear", int'(pwm_out[1]), 0);
        highs_in(1, 20, hi);
        check("R7 stays low", hi, 0);

        // R8 enable applies committed values at once, high first
        setup(1, 2, 5, 2);
        wr(wa(1, 6), 1);
        check("R8 high right after enable", int'(pwm_out[1]), 1);
        count_high(1, hi);
        check("R8 first high time", hi, 6);
        expect_wave(1, 6, 15, "R8 steady period");

        // R9 constant levels on ch2 (period 4 cycles, 12 cycles settle)
        wr(wa(2, 2), 0);
        repeat (12) @(negedge clk);
        highs_in(2, 20, hi); check("R9 duty zero low", hi, 0);
        wr(wa(2, 2), 9);
        repeat (12) @(negedge clk);
        highs_in(2, 20, hi); check("R9 duty above modulus high", hi, 20);
        wr(wa(2, 1), 0);
        wr(wa(2, 2), 3);
        repeat (12) @(negedge clk);
        highs_in(2, 20, hi); check("R9 modulus zero low", hi, 0);

        finish_up();
    end

endmodule